// File: doc/BRIEF.md
# Disk Task-File Register Device Model

This block models the device side of a disk command interface as seen by a host over a small register bus. The host selects one of two register groups with a pair of chip selects (the command group and the control group), presents a 3-bit offset, and pulses a read or a write strobe for one clock edge. Several offsets are shared: the same location returns one register when read and loads a different one when written. For example, the error code and the feature byte share an offset, as do the status and the command code. The control group always returns a copy of the status when read, and takes the reset and interrupt-mask bits when written.

When a read-sector command arrives, the model goes busy. It fills a one-sector buffer of 16-bit words from an arithmetic media pattern, one word per clock. It then presents the sector to the host with the data-request flag set and raises its interrupt. The host drains the sector by reading offset 0 once per word. The data-request flag plays the role of a ready signal: the host may read a word only while that flag is set, and the model never drops a word that the host has not read. For that reason the bus carries no valid/ready pair. Multi-sector commands refill the buffer after each drained sector. Unsupported commands and out-of-range addresses end in an error report with an interrupt.

Top module: `ata_taskfile_dev`

## Requirements
- R1: After power-on reset, status reads 0x40 (ready bit 6 set), error reads 0x00, the device/head register reads 0xA0, alternate status reads 0x40, and irq is low.
- R2: A command-group write at offset 1 (feature byte) leaves the value read at offset 1 (error code) unchanged. A command-group write at offset 7 is a command code, and a read at offset 7 returns status.
- R3: Offsets 2, 3, 4 and 5 (sector count and address bytes 7:0, 15:8 and 23:16) read back the last value written. Offset 6 reads back with bit 7 and bit 5 forced to 1, and keeps bit 6 (address mode), bit 4 (device select) and bits 3:0 (address bits 27:24).
- R4: Command 0x20 (read sectors) reads status 0x80 (busy, bit 7) while the buffer fills. It then reads 0x48 (ready plus data request, bit 3), and the interrupt is raised.
- R5: In a sector at address A, the host's k-th read of offset 0 (k = 0..255) returns {k[7:0] XOR A[7:0], A[15:8] + k[7:0]}. After the 256th read, status returns to 0x40.
- R6: A sector count of N > 1 delivers N consecutive sectors starting at the 28-bit address, with a fresh interrupt for each. A count of 0 stands for 256 sectors.
- R7: A status read (command group, offset 7) clears the pending interrupt. An alternate-status read (control group) returns the same value and leaves the interrupt pending.
- R8: Device-control bit 1 set holds irq low without discarding the pending interrupt. Clearing the bit then shows the pending interrupt on irq.
- R9: Any command code other than 0x20 ends with status 0x41 (error, bit 0), error code 0x04 (abort, bit 2) and the interrupt raised. The next accepted command clears the error.
- R10: A read whose sector address is at or beyond CAPACITY (default 0x100000) ends with status 0x41, error code 0x10 (not found, bit 4) and the interrupt raised.
- R11: While device-control bit 2 is set, status reads 0x80 and the task-file registers read their reset values. Once the bit is cleared, status reads 0x40.
- R12: A read of offset 0 while the data request is clear returns 0 and consumes no word. Task-file writes at offsets 2 to 7 are ignored while busy.
- R13: When a sector becomes ready on the same edge as a status read, the interrupt stays pending: a set has priority over a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cs_cmd | input | 1 | Selects the command register group |
| cs_ctl | input | 1 | Selects the control register group |
| addr | input | 3 | Register offset within the selected group |
| rd | input | 1 | Read strobe; side effects take place on the clock edge |
| wr | input | 1 | Write strobe |
| wdata | input | 16 | Write data (registers use bits 7:0) |
| rdata | output | 16 | Read data for the current selection |
| irq | output | 1 | Host interrupt, masked by device-control bit 1 |

## Verification
Two events can land on the same clock edge: the fill logic completing a sector, which sets the interrupt, and a host status read, which clears it. The bench provokes this by issuing a read command and then holding a status read on the bus for every cycle until the data request appears, plus one cycle more. It expects irq to be high for exactly one sampled cycle and low after the following read. Sweeps over several start addresses, including the last valid sector and a carry across address byte 0, compare every word against the arithmetic pattern.

// File: rtl/ata_dev_pkg.sv
package ata_dev_pkg;
  // command-group offsets
  localparam logic [2:0] OFS_DATA    = 3'd0;
  localparam logic [2:0] OFS_ERRFEAT = 3'd1;
  localparam logic [2:0] OFS_COUNT   = 3'd2;
  localparam logic [2:0] OFS_ADR0    = 3'd3;
  localparam logic [2:0] OFS_ADR1    = 3'd4;
  localparam logic [2:0] OFS_ADR2    = 3'd5;
  localparam logic [2:0] OFS_DEVHEAD = 3'd6;
  localparam logic [2:0] OFS_STATCMD = 3'd7;

  // status bits
  localparam int ST_BSY  = 7;
  localparam int ST_DRDY = 6;
  localparam int ST_DRQ  = 3;
  localparam int ST_ERR  = 0;

  // error code bits
  localparam int ER_IDNF = 4;
  localparam int ER_ABRT = 2;

  // device-control bits
  localparam int DC_SRST = 2;
  localparam int DC_NIEN = 1;

  localparam logic [7:0] CMD_READ_SECT = 8'h20;

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_XFER, S_FAIL} phase_e;

  // arithmetic media pattern for word idx of sector lba
  function automatic logic [15:0] media_word(input logic [27:0] lba, input logic [7:0] idx);
    media_word = {idx ^ lba[7:0], lba[15:8] + idx};
  endfunction
endpackage

// File: rtl/ata_bus_decode.sv
module ata_bus_decode
  import ata_dev_pkg::*;
(
  input  logic       cs_cmd,
  input  logic       cs_ctl,
  input  logic [2:0] addr,
  input  logic       rd,
  input  logic       wr,
  output logic [5:0] tf_wr,    // bit k: write to command-group offset k+2
  output logic       ctl_wr,
  output logic       data_rd,
  output logic       stat_rd,
  output logic       alt_rd
);
  logic cmd_sel, ctl_sel;
  assign cmd_sel = cs_cmd && !cs_ctl;
  assign ctl_sel = cs_ctl && !cs_cmd;

  for (genvar k = 0; k < 6; k++) begin : g_wr
    assign tf_wr[k] = cmd_sel && wr && (addr == 3'(k + 2));
  end

  assign ctl_wr  = ctl_sel && wr;
  assign data_rd = cmd_sel && rd && (addr == OFS_DATA);
  assign stat_rd = cmd_sel && rd && (addr == OFS_STATCMD);
  assign alt_rd  = ctl_sel && rd;
endmodule

// File: rtl/ata_sector_buf.sv
module ata_sector_buf #(
  parameter int WORDS = 256,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [15:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [15:0]   rdata
);
  logic [15:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/ata_cmd_ctrl.sv
module ata_cmd_ctrl
  import ata_dev_pkg::*;
#(
  parameter int WORDS = 256,
  parameter logic [27:0] CAPACITY = 28'h0100000,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          srst,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_code,
  input  logic [27:0]   lba_in,
  input  logic [7:0]    count_in,
  input  logic          data_rd,
  input  logic          stat_rd,
  output logic [7:0]    status,
  output logic [7:0]    error,
  output logic          busy,
  output logic          drq,
  output logic          irq_pend,
  output logic          buf_we,
  output logic [AW-1:0] buf_waddr,
  output logic [15:0]   buf_wdata,
  output logic [AW-1:0] buf_raddr
);
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  phase_e        phase;
  logic [AW-1:0] fill_idx, rd_ptr;
  logic [8:0]    secs_left;
  logic [27:0]   cur_lba, next_lba;
  logic          err, intrq, accept, set_irq;
  logic [7:0]    err_bits, fail_bits;

  assign busy     = srst || (phase == S_FILL) || (phase == S_FAIL);
  assign drq      = (phase == S_XFER);
  assign accept   = cmd_wr && !busy;
  assign set_irq  = (phase == S_FAIL) || ((phase == S_FILL) && (fill_idx == LAST));
  assign next_lba = cur_lba + 28'd1;

  always_comb begin
    status = '0;
    if (busy) status[ST_BSY] = 1'b1;
    else begin
      status[ST_DRDY] = 1'b1;
      status[ST_DRQ]  = drq;
      status[ST_ERR]  = err;
    end
  end

  assign error     = err_bits;
  assign irq_pend  = intrq;
  assign buf_we    = (phase == S_FILL);
  assign buf_waddr = fill_idx;
  assign buf_wdata = media_word(cur_lba, 8'(fill_idx));
  assign buf_raddr = rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= S_IDLE; fill_idx <= '0; rd_ptr <= '0; secs_left <= '0;
      cur_lba <= '0; err <= 1'b0; err_bits <= '0; fail_bits <= '0; intrq <= 1'b0;
    end else if (srst) begin
      phase <= S_IDLE; fill_idx <= '0; rd_ptr <= '0; secs_left <= '0;
      cur_lba <= '0; err <= 1'b0; err_bits <= '0; fail_bits <= '0; intrq <= 1'b0;
    end else begin
      if (set_irq) intrq <= 1'b1;
      else if (stat_rd || accept) intrq <= 1'b0;

      if (accept) begin
        err      <= 1'b0;
        err_bits <= '0;
        rd_ptr   <= '0;
        fill_idx <= '0;
        if (cmd_code != CMD_READ_SECT) begin
          phase     <= S_FAIL;
          fail_bits <= 8'(1 << ER_ABRT);
        end else if (lba_in >= CAPACITY) begin
          phase     <= S_FAIL;
          fail_bits <= 8'(1 << ER_IDNF);
        end else begin
          phase     <= S_FILL;
          cur_lba   <= lba_in;
          secs_left <= (count_in == 8'd0) ? 9'd256 : {1'b0, count_in};
        end
      end else begin
        case (phase)
          S_FILL: begin
            fill_idx <= fill_idx + 1'b1;
            if (fill_idx == LAST) phase <= S_XFER;
          end
          S_FAIL: begin
            err      <= 1'b1;
            err_bits <= fail_bits;
            phase    <= S_IDLE;
          end
          S_XFER: begin
            if (data_rd) begin
              rd_ptr <= rd_ptr + 1'b1;
              if (rd_ptr == LAST) begin
                secs_left <= secs_left - 9'd1;
                if (secs_left == 9'd1) phase <= S_IDLE;
                else if (next_lba >= CAPACITY) begin
                  phase     <= S_FAIL;
                  fail_bits <= 8'(1 << ER_IDNF);
                end else begin
                  cur_lba  <= next_lba;
                  fill_idx <= '0;
                  phase    <= S_FILL;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R9
  err_not_filling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (phase != S_FILL));

  // R12
  ptr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_ptr != $past(rd_ptr)) && (rd_ptr != '0)) |-> ($past(drq) && $past(data_rd)));

  // R13
  irq_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_irq && !srst) |=> intrq);

  // R7
  stat_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !set_irq) |=> !intrq);

  // R4
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intrq) |-> (drq || err));
endmodule

// File: rtl/ata_taskfile_dev.sv
module ata_taskfile_dev
  import ata_dev_pkg::*;
#(
  parameter int WORDS = 256,
  parameter logic [27:0] CAPACITY = 28'h0100000,
  localparam int AW = $clog2(WORDS)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_cmd,
  input  logic        cs_ctl,
  input  logic [2:0]  addr,
  input  logic        rd,
  input  logic        wr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  logic [5:0]    tf_wr;
  logic          ctl_wr, data_rd, stat_rd, alt_rd;
  logic [7:0]    cnt_q, adr0_q, adr1_q, adr2_q;
  logic [3:0]    adrhi_q;
  logic          devsel_q, lbamode_q, srst_q, nien_q;
  logic [7:0]    status, error;
  logic          busy, drq, irq_pend, buf_we;
  logic [AW-1:0] buf_waddr, buf_raddr;
  logic [15:0]   buf_wdata, buf_rdata;
  logic          unused_alt_rd;
  logic [7:0]    unused_wdata_hi;

  assign unused_alt_rd   = alt_rd;
  assign unused_wdata_hi = wdata[15:8];

  ata_bus_decode u_dec (
    .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr), .rd(rd), .wr(wr),
    .tf_wr(tf_wr), .ctl_wr(ctl_wr), .data_rd(data_rd), .stat_rd(stat_rd), .alt_rd(alt_rd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; adr0_q <= '0; adr1_q <= '0; adr2_q <= '0;
      adrhi_q <= '0; devsel_q <= 1'b0; lbamode_q <= 1'b0;
      srst_q <= 1'b0; nien_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        srst_q <= wdata[DC_SRST];
        nien_q <= wdata[DC_NIEN];
      end
      if (srst_q) begin
        cnt_q <= '0; adr0_q <= '0; adr1_q <= '0; adr2_q <= '0;
        adrhi_q <= '0; devsel_q <= 1'b0; lbamode_q <= 1'b0;
      end else if (!busy) begin
        if (tf_wr[0]) cnt_q  <= wdata[7:0];
        if (tf_wr[1]) adr0_q <= wdata[7:0];
        if (tf_wr[2]) adr1_q <= wdata[7:0];
        if (tf_wr[3]) adr2_q <= wdata[7:0];
        if (tf_wr[4]) begin
          adrhi_q   <= wdata[3:0];
          devsel_q  <= wdata[4];
          lbamode_q <= wdata[6];
        end
      end
    end
  end

  ata_cmd_ctrl #(.WORDS(WORDS), .CAPACITY(CAPACITY)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .srst(srst_q),
    .cmd_wr(tf_wr[5]), .cmd_code(wdata[7:0]),
    .lba_in({adrhi_q, adr2_q, adr1_q, adr0_q}), .count_in(cnt_q),
    .data_rd(data_rd), .stat_rd(stat_rd),
    .status(status), .error(error), .busy(busy), .drq(drq), .irq_pend(irq_pend),
    .buf_we(buf_we), .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .buf_raddr(buf_raddr)
  );

  ata_sector_buf #(.WORDS(WORDS)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  always_comb begin
    rdata = '0;
    if (cs_cmd && !cs_ctl) begin
      case (addr)
        OFS_DATA:    rdata = drq ? buf_rdata : 16'h0000;
        OFS_ERRFEAT: rdata = {8'h00, error};
        OFS_COUNT:   rdata = {8'h00, cnt_q};
        OFS_ADR0:    rdata = {8'h00, adr0_q};
        OFS_ADR1:    rdata = {8'h00, adr1_q};
        OFS_ADR2:    rdata = {8'h00, adr2_q};
        OFS_DEVHEAD: rdata = {8'h00, 1'b1, lbamode_q, 1'b1, devsel_q, adrhi_q};
        default:     rdata = {8'h00, status};
      endcase
    end else if (cs_ctl && !cs_cmd) begin
      rdata = {8'h00, status};
    end
  end

  assign irq = irq_pend && !nien_q;

  // R11
  srst_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(srst_q) && srst_q && cs_ctl && !cs_cmd) |-> (rdata == 16'h0080));
endmodule

// File: tb/tb_ata_taskfile_dev.sv
module tb_ata_taskfile_dev;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        cs_cmd = 1'b0, cs_ctl = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [15:0] q;
  int          checks = 0, fails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  ata_taskfile_dev dut (
    .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd), .cs_ctl(cs_ctl), .addr(addr),
    .rd(rd), .wr(wr), .wdata(wdata), .rdata(rdata), .irq(irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus(input bit ctl, input bit w, input logic [2:0] a,
                     input logic [15:0] d, output logic [15:0] r);
    @(negedge clk);
    cs_cmd = !ctl; cs_ctl = ctl; addr = a; wr = w; rd = !w; wdata = d;
    #1 r = rdata;
    @(posedge clk);
    #1 cs_cmd = 1'b0; cs_ctl = 1'b0; rd = 1'b0; wr = 1'b0;
  endtask

  task automatic wr_tf(input logic [2:0] a, input logic [7:0] d);
    logic [15:0] dummy;
    bus(1'b0, 1'b1, a, {8'h00, d}, dummy);
  endtask

  task automatic wr_ctl(input logic [7:0] d);
    logic [15:0] dummy;
    bus(1'b1, 1'b1, 3'd0, {8'h00, d}, dummy);
  endtask

  task automatic rd_tf(input logic [2:0] a);
    bus(1'b0, 1'b0, a, 16'h0, q);
  endtask

  task automatic rd_alt();
    bus(1'b1, 1'b0, 3'd0, 16'h0, q);
  endtask

  task automatic setup(input logic [27:0] lba, input logic [7:0] cnt);
    wr_tf(3'd2, cnt);
    wr_tf(3'd3, lba[7:0]);
    wr_tf(3'd4, lba[15:8]);
    wr_tf(3'd5, lba[23:16]);
    wr_tf(3'd6, {4'hE, lba[27:24]});
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 2000; i++) begin
      rd_alt();
      if (!q[7]) break;
    end
  endtask

  function automatic logic [15:0] exp_word(input logic [27:0] lba, input int k);
    logic [7:0] kk;
    kk = 8'(k);
    return {kk ^ lba[7:0], lba[15:8] + kk};
  endfunction

  task automatic drain(input logic [27:0] lba, input string req);
    int bad = 0;
    logic [15:0] first_act = 16'h0, first_exp = 16'h0;
    for (int k = 0; k < 256; k++) begin
      rd_tf(3'd0);
      if (q !== exp_word(lba, k)) begin
        if (bad == 0) begin first_act = q; first_exp = exp_word(lba, k); end
        bad++;
      end
    end
    chk({req, " first word mismatch"}, first_act, first_exp);
    chk({req, " mismatching words"}, 16'(bad), 16'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int hits;
    logic [27:0] sweep [4];
    sweep[0] = 28'h0000000; sweep[1] = 28'h0001234;
    sweep[2] = 28'h000FFFF; sweep[3] = 28'h00FFFFF;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    #1 chk("R1 irq", {15'h0, irq}, 16'h0);
    rd_tf(3'd7); chk("R1 status", q, 16'h0040);
    rd_tf(3'd1); chk("R1 error", q, 16'h0000);
    rd_tf(3'd6); chk("R1 devhead", q, 16'h00A0);
    rd_alt();    chk("R1 alt status", q, 16'h0040);

    // R3 readback
    wr_tf(3'd2, 8'h05); wr_tf(3'd3, 8'h12); wr_tf(3'd4, 8'h34); wr_tf(3'd5, 8'h56);
    rd_tf(3'd2); chk("R3 count", q, 16'h0005);
    rd_tf(3'd3); chk("R3 adr0", q, 16'h0012);
    rd_tf(3'd4); chk("R3 adr1", q, 16'h0034);
    rd_tf(3'd5); chk("R3 adr2", q, 16'h0056);
    wr_tf(3'd6, 8'h4B); rd_tf(3'd6); chk("R3 devhead 4B", q, 16'h00EB);
    wr_tf(3'd6, 8'h10); rd_tf(3'd6); chk("R3 devhead 10", q, 16'h00B0);

    // R2 shared offsets
    wr_tf(3'd1, 8'h77); rd_tf(3'd1); chk("R2 feature not readable", q, 16'h0000);
    rd_tf(3'd7); chk("R2 offset7 reads status", q, 16'h0040);

    // R4 / R7 single sector
    setup(28'h0001234, 8'd1);
    wr_tf(3'd7, 8'h20);
    rd_alt(); chk("R4 busy during fill", q, 16'h0080);
    wait_ready();
    chk("R4 ready with data", q, 16'h0048);
    chk("R4 irq raised", {15'h0, irq}, 16'h1);
    rd_alt(); chk("R7 alt value", q, 16'h0048);
    chk("R7 alt keeps irq", {15'h0, irq}, 16'h1);
    rd_tf(3'd7); chk("R7 status value", q, 16'h0048);
    chk("R7 status clears irq", {15'h0, irq}, 16'h0);
    drain(28'h0001234, "R5 sector 1234");
    rd_tf(3'd7); chk("R5 status after drain", q, 16'h0040);

    // R12 data read without data request
    rd_tf(3'd0); chk("R12 data idle zero", q, 16'h0000);
    rd_tf(3'd7); chk("R12 status unchanged", q, 16'h0040);

    // R5 sweep of start addresses
    for (int s = 0; s < 4; s++) begin
      setup(sweep[s], 8'd1);
      wr_tf(3'd7, 8'h20);
      wait_ready();
      chk("R5 sweep ready", q, 16'h0048);
      rd_tf(3'd7);
      drain(sweep[s], "R5 sweep");
    end

    // R6 multi-sector with carry across byte 0
    setup(28'h00000FF, 8'd3);
    wr_tf(3'd7, 8'h20);
    for (int n = 0; n < 3; n++) begin
      wait_ready();
      chk("R6 sector ready", q, 16'h0048);
      chk("R6 per-sector irq", {15'h0, irq}, 16'h1);
      rd_tf(3'd7);
      drain(28'h00000FF + 28'(n), "R6 multi");
    end
    rd_tf(3'd7); chk("R6 done status", q, 16'h0040);

    // R12 writes ignored while busy
    setup(28'h0000010, 8'd1);
    wr_tf(3'd7, 8'h20);
    wr_tf(3'd2, 8'h33);
    wait_ready();
    rd_tf(3'd2); chk("R12 busy write ignored", q, 16'h0001);
    rd_tf(3'd7);
    drain(28'h0000010, "R12 sector");

    // R8 interrupt mask
    wr_ctl(8'h02);
    setup(28'h0000020, 8'd1);
    wr_tf(3'd7, 8'h20);
    wait_ready();
    chk("R8 masked irq", {15'h0, irq}, 16'h0);
    wr_ctl(8'h00);
    chk("R8 pending revealed", {15'h0, irq}, 16'h1);
    rd_tf(3'd7);
    drain(28'h0000020, "R8 sector");

    // R9 unsupported command
    wr_tf(3'd7, 8'h99);
    wait_ready();
    chk("R9 status", q, 16'h0041);
    rd_tf(3'd1); chk("R9 error abort", q, 16'h0004);
    chk("R9 irq", {15'h0, irq}, 16'h1);

    // R10 out of range
    setup(28'h0100000, 8'd1);
    wr_tf(3'd7, 8'h20);
    wait_ready();
    chk("R10 status", q, 16'h0041);
    rd_tf(3'd1); chk("R10 error not found", q, 16'h0010);
    rd_tf(3'd7);
    chk("R10 irq cleared by status", {15'h0, irq}, 16'h0);

    // R9 next command clears error
    setup(28'h0000030, 8'd1);
    wr_tf(3'd7, 8'h20);
    wait_ready();
    chk("R9 error cleared", q, 16'h0048);
    rd_tf(3'd7);
    drain(28'h0000030, "R9 sector");

    // R11 soft reset
    wr_tf(3'd2, 8'h09);
    wr_ctl(8'h04);
    rd_alt(); chk("R11 busy in reset", q, 16'h0080);
    rd_tf(3'd2); chk("R11 count reset", q, 16'h0000);
    wr_ctl(8'h00);
    rd_alt(); chk("R11 ready after reset", q, 16'h0040);

    // R13 completion on the same edge as a status read
    setup(28'h0000040, 8'd1);
    wr_tf(3'd7, 8'h20);
    hits = 0;
    @(negedge clk);
    cs_cmd = 1'b1; addr = 3'd7; rd = 1'b1;
    for (int c = 0; c < 1000; c++) begin
      @(negedge clk); #1;
      if (irq) hits++;
      if (rdata[3]) break;
    end
    @(negedge clk); #1;
    if (irq) hits++;
    cs_cmd = 1'b0; rd = 1'b0;
    chk("R13 irq visible once", 16'(hits), 16'd1);
    chk("R13 irq cleared afterwards", {15'h0, irq}, 16'h0);
    drain(28'h0000040, "R13 sector");

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule